// File: doc/BRIEF.md
# Chip-Select Memory Access Sequencer

This block runs one external memory access at a time on behalf of an internal bus master. The master offers a request on a valid/ready port, together with a bank index and a read flag. The block then drives the bank's chip-select line, the output-enable strobe for reads and a held read/write level. It ends the access with a one-cycle transfer acknowledge. The acknowledge comes either from its own wait-state counter or from an external acknowledge input.

Each bank has four settings. The first is a 4-bit wait count. The second is a slow-timing bit, which starts chip select one clock late and doubles the wait count, capped at 30. The third is an external-only bit, which turns off the internal acknowledge so the access waits for the external one. The fourth is a read-hold bit, which adds one idle clock after a read from that bank. No idle clock is added when the next access is a read to the same bank.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the master keeps the bank and read flag stable. `req_ready` is low from the accepting edge until the acknowledge cycle has passed. It is also low during a pending idle clock for any request that is not a same-bank read. Bank settings are captured at the accepting edge.

Top module: `csm_timing_engine`

## Requirements
- R1: After reset, all chip selects, `oe` and `xfer_ack` are low, and `req_ready` is high.
- R2: Only one access is outstanding. `req_ready` is low in every cycle in which a chip select is high.
- R3: Chip select is active high, with bit i of `cs` belonging to bank i, and only the addressed bank's line rises. With the slow bit clear, it goes high in the first cycle after the accepting edge. With the slow bit set, it goes high in the second cycle.
- R4: `rd_wr` (1 = read) equals the request's read flag in every chip-select cycle. `oe` is high only for reads. It rises one cycle after chip select rises, in both timing modes, and falls together with chip select.
- R5: With the external-only bit clear, chip select stays high for W+2 cycles, with W equal to the wait count (0 to 15). `xfer_ack` is high for exactly one cycle, the last chip-select cycle.
- R6: With the slow bit set, W is twice the wait count, capped at 30.
- R7: With the external-only bit clear, `ext_ack` sampled in chip-select cycle k (k = 0 for the first) ends the access early when W−k ≥ 2. The acknowledge then comes in cycle k+1. Otherwise `ext_ack` has no effect.
- R8: With the external-only bit set, chip select stays high until `ext_ack` is sampled in chip-select cycle k, for any k. The acknowledge comes in cycle k+1.
- R9: After a read from a bank whose read-hold bit is set, the next access has two chip-select-low cycles before its chip select rises instead of one. The exception is a read to the same bank, which keeps one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Master offers an access |
| req_ready | output | 1 | Block accepts the offered access this cycle |
| req_bank | input | BANK_W | Bank index of the access |
| req_rd | input | 1 | 1 = read, 0 = write |
| ext_ack | input | 1 | External transfer acknowledge |
| cfg_wait | input | NUM_BANKS*4 | Wait count per bank, bank i at bits 4i+3:4i |
| cfg_slow | input | NUM_BANKS | Slow-timing bit per bank |
| cfg_ext_only | input | NUM_BANKS | Internal acknowledge disabled per bank |
| cfg_rd_hold | input | NUM_BANKS | Idle clock after reads per bank |
| cs | output | NUM_BANKS | Chip select per bank, active high |
| oe | output | 1 | Output enable, active high |
| rd_wr | output | 1 | Direction of the current access, 1 = read |
| xfer_ack | output | 1 | Transfer acknowledge to the master, one cycle |

## Verification
The main sweep runs every wait count in both timing modes, for reads and writes, on each bank. This separates the start offset of chip select, its length, the position of the acknowledge and the output-enable gating for every combination. Further cases place an external acknowledge just inside and just outside the two-clock margin, and hold one off for many cycles with the internal acknowledge disabled. These show early termination apart from an input that is ignored. Back-to-back pairs follow reads and writes from a read-hold bank with writes, reads to the other bank and reads to the same bank. The measured idle gap shows where the extra clock is inserted and where it is skipped.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int WAIT_W         = 4;
  localparam int CNT_W          = WAIT_W + 1;
  localparam int MAX_SLOW_WAIT  = 30;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ACK   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] wait_eff;
    logic             slow;
    logic             ext_only;
    logic             rd_hold;
  } bank_cfg_t;
endpackage

// File: rtl/csm_bank_cfg.sv
module csm_bank_cfg
  import csm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic [BANK_W-1:0]           bank,
  input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait,
  input  logic [NUM_BANKS-1:0]        cfg_slow,
  input  logic [NUM_BANKS-1:0]        cfg_ext_only,
  input  logic [NUM_BANKS-1:0]        cfg_rd_hold,
  output bank_cfg_t                   sel
);
  bank_cfg_t per_bank [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WAIT_W-1:0] scy;
    logic [CNT_W-1:0]  doubled;
    assign scy     = cfg_wait[b*WAIT_W +: WAIT_W];
    assign doubled = {scy, 1'b0};
    always_comb begin
      per_bank[b].slow     = cfg_slow[b];
      per_bank[b].ext_only = cfg_ext_only[b];
      per_bank[b].rd_hold  = cfg_rd_hold[b];
      if (!cfg_slow[b])
        per_bank[b].wait_eff = {1'b0, scy};
      else if (doubled > CNT_W'(MAX_SLOW_WAIT))
        per_bank[b].wait_eff = CNT_W'(MAX_SLOW_WAIT);
      else
        per_bank[b].wait_eff = doubled;
    end
  end

  always_comb begin
    if ({1'b0, bank} < (BANK_W+1)'(NUM_BANKS))
      sel = per_bank[bank];
    else
      sel = '0;
  end
endmodule

// File: rtl/csm_seq.sv
module csm_seq
  import csm_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_rd,
  input  bank_cfg_t         req_cfg,
  input  logic              ext_ack,
  output logic              cs_on,
  output logic [BANK_W-1:0] cs_bank,
  output logic              oe,
  output logic              rd_wr,
  output logic              xfer_ack
);
  seq_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BANK_W-1:0] bank_q, hold_bank;
  logic              rd_q, ext_only_q, rd_hold_q, first_q, hold_pend;
  logic              accept, ext_end, int_end;

  assign req_ready = (st == ST_IDLE) &&
                     (!hold_pend || (req_rd && req_bank == hold_bank));
  assign accept    = req_valid && req_ready;
  assign ext_end   = ext_ack && (ext_only_q || cnt >= CNT_W'(2));
  assign int_end   = !ext_only_q && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      bank_q     <= '0;
      hold_bank  <= '0;
      rd_q       <= 1'b0;
      ext_only_q <= 1'b0;
      rd_hold_q  <= 1'b0;
      first_q    <= 1'b0;
      hold_pend  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          hold_pend <= 1'b0;
          if (accept) begin
            bank_q     <= req_bank;
            rd_q       <= req_rd;
            ext_only_q <= req_cfg.ext_only;
            rd_hold_q  <= req_cfg.rd_hold;
            cnt        <= req_cfg.wait_eff;
            first_q    <= 1'b1;
            st         <= req_cfg.slow ? ST_SETUP : ST_WAIT;
          end
        end
        ST_SETUP: st <= ST_WAIT;
        ST_WAIT: begin
          first_q <= 1'b0;
          if (ext_end || int_end) st <= ST_ACK;
          else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
        end
        default: begin
          st        <= ST_IDLE;
          hold_pend <= rd_q && rd_hold_q;
          hold_bank <= bank_q;
        end
      endcase
    end
  end

  assign cs_on    = (st == ST_WAIT) || (st == ST_ACK);
  assign cs_bank  = bank_q;
  assign rd_wr    = rd_q;
  assign xfer_ack = (st == ST_ACK);
  assign oe       = rd_q && ((st == ST_WAIT && !first_q) || st == ST_ACK);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_on |-> !req_ready);
  assert_oe_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(cs_on));
  assert_oe_falls_with_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_on) |-> !oe);
  assert_dir_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && $past(cs_on)) |-> $stable(rd_wr));
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);
  assert_ack_ends_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !cs_on);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_SLOW_WAIT));
endmodule

// File: rtl/csm_cs_decode.sv
module csm_cs_decode #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 on,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] cs
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_line
    assign cs[i] = on && (bank == BANK_W'(i));
  end

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));
  assert_cs_needs_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != '0) |-> on);
endmodule

// File: rtl/csm_timing_engine.sv
module csm_timing_engine
  import csm_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic                        req_rd,
  input  logic                        ext_ack,
  input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait,
  input  logic [NUM_BANKS-1:0]        cfg_slow,
  input  logic [NUM_BANKS-1:0]        cfg_ext_only,
  input  logic [NUM_BANKS-1:0]        cfg_rd_hold,
  output logic [NUM_BANKS-1:0]        cs,
  output logic                        oe,
  output logic                        rd_wr,
  output logic                        xfer_ack
);
  bank_cfg_t         sel_cfg;
  logic              cs_on;
  logic [BANK_W-1:0] cs_bank;

  csm_bank_cfg #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_cfg (
    .bank(req_bank), .cfg_wait(cfg_wait), .cfg_slow(cfg_slow),
    .cfg_ext_only(cfg_ext_only), .cfg_rd_hold(cfg_rd_hold), .sel(sel_cfg)
  );

  csm_seq #(.BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_rd(req_rd), .req_cfg(sel_cfg), .ext_ack(ext_ack),
    .cs_on(cs_on), .cs_bank(cs_bank), .oe(oe), .rd_wr(rd_wr), .xfer_ack(xfer_ack)
  );

  csm_cs_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .on(cs_on), .bank(cs_bank), .cs(cs)
  );
endmodule

// File: tb/csm_timing_engine_bench.sv
module csm_timing_engine_bench;
  localparam int NB = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0, ext_ack = 1'b0;
  logic [0:0] req_bank = '0;
  logic req_ready, oe, rd_wr, xfer_ack;
  logic [NB*4-1:0] cfg_wait = '0;
  logic [NB-1:0] cfg_slow = '0, cfg_ext_only = '0, cfg_rd_hold = '0;
  logic [NB-1:0] cs;
  int total = 0, bad = 0;
  int lowcnt = 100, gap = -1;
  bit prev_cs = 0;

  always #10 clk = ~clk;

  csm_timing_engine #(.NUM_BANKS(NB)) u_csm_timing_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_rd(req_rd), .ext_ack(ext_ack), .cfg_wait(cfg_wait),
    .cfg_slow(cfg_slow), .cfg_ext_only(cfg_ext_only), .cfg_rd_hold(cfg_rd_hold),
    .cs(cs), .oe(oe), .rd_wr(rd_wr), .xfer_ack(xfer_ack)
  );

  always @(negedge clk) begin
    if (|cs) begin
      if (!prev_cs) gap = lowcnt;
      lowcnt = 0; prev_cs = 1;
    end else begin
      lowcnt++; prev_cs = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  int cs_start, len, oe_start, ack_at, other, busy, rwbad;

  task automatic do_acc(input int bank, input bit rd, input int ext_k);
    req_bank = 1'(bank); req_rd = rd; req_valid = 1'b1; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; req_valid = 1'b0;
    cs_start = -1; len = 0; oe_start = -1; ack_at = -1; other = 0; busy = 0; rwbad = 0;
    for (int idx = 1; idx <= 60 && ack_at < 0; idx++) begin
      @(negedge clk);
      if (cs[bank]) begin
        if (cs_start < 0) cs_start = idx;
        len++;
        if (rd_wr !== rd) rwbad++;
        if (req_ready) busy++;
      end
      if ((cs & ~(NB'(1) << bank)) != '0) other++;
      if (oe && oe_start < 0) oe_start = idx;
      if (oe && (!cs[bank] || !rd)) rwbad++;
      if (xfer_ack) ack_at = idx;
      ext_ack = (ext_k >= 0 && cs_start >= 0 && idx - cs_start == ext_k);
    end
    ext_ack = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R2 watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs == '0, "R1 cs", int'(cs), 0);
    chk(!oe && !xfer_ack, "R1 oe/ack", int'({oe, xfer_ack}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready, "R1 ready", int'(req_ready), 1);

    // R3 R4 R5 R6 sweep
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 16; w++)
          for (int r = 0; r < 2; r++) begin
            int weff, st_e;
            cfg_wait[b*4 +: 4] = 4'(w); cfg_slow[b] = 1'(s);
            weff = s ? 2*w : w;
            st_e = s ? 2 : 1;
            do_acc(b, 1'(r), -1);
            chk(cs_start == st_e, s ? "R6 cs start slow" : "R3 cs start", cs_start, st_e);
            chk(len == weff + 2, s ? "R6 length" : "R5 length", len, weff + 2);
            chk(ack_at == st_e + weff + 1, "R5 ack position", ack_at, st_e + weff + 1);
            chk(oe_start == (r ? st_e + 1 : -1), "R4 oe start", oe_start, r ? st_e + 1 : -1);
            chk(rwbad == 0, "R4 dir/oe", rwbad, 0);
            chk(other == 0, "R3 other bank", other, 0);
            chk(busy == 0, "R2 ready while busy", busy, 0);
          end

    // R7 early external acknowledge
    cfg_slow = '0; cfg_wait[3:0] = 4'd5;
    do_acc(0, 1'b1, 3); chk(len == 5, "R7 early end k=3", len, 5);
    do_acc(0, 1'b1, 4); chk(len == 7, "R7 ignored k=4", len, 7);
    do_acc(0, 1'b0, 0); chk(len == 2, "R7 early end k=0", len, 2);
    do_acc(0, 1'b0, 5); chk(len == 7, "R7 ignored k=5", len, 7);

    // R8 external only
    cfg_ext_only[0] = 1'b1; cfg_wait[3:0] = 4'd0;
    do_acc(0, 1'b1, 20);
    chk(len == 22, "R8 long wait", len, 22);
    chk(ack_at == cs_start + 21, "R8 ack position", ack_at, cs_start + 21);
    do_acc(0, 1'b0, 0); chk(len == 2, "R8 k=0", len, 2);
    cfg_ext_only = '0;

    // R9 idle clock after reads from read-hold bank
    cfg_wait = '0; cfg_rd_hold = 2'b01;
    do_acc(0, 1'b1, -1); do_acc(0, 1'b0, -1); chk(gap == 2, "R9 read then write same bank", gap, 2);
    do_acc(0, 1'b1, -1); do_acc(1, 1'b1, -1); chk(gap == 2, "R9 read then other bank", gap, 2);
    do_acc(0, 1'b1, -1); do_acc(0, 1'b1, -1); chk(gap == 1, "R9 same bank read", gap, 1);
    do_acc(0, 1'b0, -1); do_acc(1, 1'b1, -1); chk(gap == 1, "R9 after write", gap, 1);
    do_acc(1, 1'b1, -1); do_acc(0, 1'b0, -1); chk(gap == 1, "R9 non-hold bank", gap, 1);
    cfg_rd_hold = '0;
    do_acc(0, 1'b1, -1); do_acc(0, 1'b0, -1); chk(gap == 1, "R9 hold off", gap, 1);

    summary();
  end
endmodule